// File: doc/BRIEF.md
# Trace Byte Stream Decoder

This block sits on the receiving side of an execution-trace link. Bytes arrive one per valid/ready handshake and form groups: a group is opened by one marker byte and closed by another. Between them come variable-length items, each introduced by an opcode byte. The items are register writes, privilege, PC, effective-address and store-data state, 16-bit or 32-bit instructions, payload-free hart-reset and state-init markers, and memory requests. Every payload is little-endian. Some payload lengths follow the XLEN parameter (32 or 64) and others follow a size code carried in the stream.

The decoder turns each completed item into one output event. An event carries a kind tag, a 16-bit register number and a 64-bit value. The exception is a memory request, which yields an address event and then a data event. Events leave through a one-deep holding register with a valid/ready handshake, and the input is back-pressured while an event waits. A one-cycle group-done pulse marks each close byte. Malformed input raises a sticky error flag, and the decoder then skips bytes until the next open byte.

Top module: `trace_stream_parser`

## Requirements
- R1: Byte 0x01 opens a group and, at an opcode position, byte 0x02 closes it. The close byte produces a one-cycle `grp_done` pulse in the cycle after it is accepted.
- R2: Opcode 0x04 is followed by a 16-bit register number (low byte first) and then XLEN/8 value bytes (low byte first). It yields kind 0 with that register number and the value, zero-extended.
- R3: Opcode 0x07 is followed by a subtype byte. Subtype 0x01 takes 1 payload byte and yields kind 1. Subtype 0x0A takes XLEN/8 bytes and yields kind 2 (PC). Subtype 0x03 takes XLEN/8 bytes and yields kind 3 (effective address). All three carry register number 0.
- R4: Subtypes 0x04, 0x05, 0x06 and 0x07 take 1, 2, 4 and 8 payload bytes respectively. They yield kind 4, with the register number equal to the size code 0..3 and the value zero-extended.
- R5: Opcode 0x10 takes a 2-byte instruction and yields kind 5. Opcode 0x11 takes a 4-byte instruction and yields kind 6. Both carry register number 0.
- R6: Opcode 0x0A yields kind 7 and opcode 0x0B yields kind 8, each with register number 0 and value 0, from the opcode byte alone.
- R7: Opcode 0x08 is followed by XLEN/8 address bytes, which yield kind 9 (register number 0, value = address). Then comes one attribute byte, whose bits [5:4] are a size code, followed by 2^size data bytes. These yield kind 10, with the register number equal to the attribute byte zero-extended and value = data.
- R8: An item's event becomes valid in the cycle after its final byte is accepted. It holds its fields stable while `ev_ready` is low. `in_ready` is low exactly while an event is valid and not being taken, so no event is lost or duplicated.
- R9: An unknown opcode, an unknown subtype, or any byte other than 0x01 between groups sets `err_flag`. The flag stays set until reset. The decoder then drops bytes, producing no event and no `grp_done`, until the next 0x01 byte opens a group.
- R10: A synchronous reset returns the decoder to the between-groups state. It discards any partial item, clears `err_flag` and leaves no event valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input trace byte |
| in_ready | output | 1 | Decoder can take a byte |
| ev_valid | output | 1 | Decoded event valid |
| ev_ready | input | 1 | Consumer takes the event |
| ev_kind | output | 4 | Event kind tag |
| ev_regnum | output | 16 | Register number or attribute field |
| ev_value | output | 64 | Event value, zero-extended |
| grp_done | output | 1 | One-cycle pulse after a close byte |
| err_flag | output | 1 | Sticky format error |

## Verification
Two functions can land on the same clock edge. The consumer can drain the held event on the same edge that a new item's final byte, or a payload-free marker, reloads the holding register. Runs of back-to-back markers and short items are mixed with a randomly toggling `ev_ready` to create exactly that collision, and separate phases hold `ev_ready` low to force stalls. Each event taken is compared in order against a list that the bench builds while encoding the stream, so a dropped, repeated or corrupted event shows up as a mismatch or as an unexpected event.

// File: rtl/trc_pkg.sv
package trc_pkg;

   typedef enum logic [3:0] {
      K_REGWR  = 4'd0,
      K_PRIV   = 4'd1,
      K_PC     = 4'd2,
      K_EADDR  = 4'd3,
      K_STDATA = 4'd4,
      K_INS16  = 4'd5,
      K_INS32  = 4'd6,
      K_HRST   = 4'd7,
      K_SINIT  = 4'd8,
      K_MADDR  = 4'd9,
      K_MDATA  = 4'd10
   } trc_kind_e;

   typedef enum logic [3:0] {
      ST_OUT, ST_OPC, ST_RNUM, ST_RVAL, ST_SUB,
      ST_ASPAY, ST_INSTR, ST_MADDR, ST_MATTR, ST_MDATA
   } trc_state_e;

   localparam logic [7:0] B_OPEN  = 8'd1;
   localparam logic [7:0] B_CLOSE = 8'd2;
   localparam logic [7:0] B_REGW  = 8'd4;
   localparam logic [7:0] B_AUX   = 8'd7;
   localparam logic [7:0] B_MREQ  = 8'd8;
   localparam logic [7:0] B_HRST  = 8'd10;
   localparam logic [7:0] B_SINIT = 8'd11;
   localparam logic [7:0] B_INS16 = 8'd16;
   localparam logic [7:0] B_INS32 = 8'd17;

   localparam logic [7:0] SUB_PRIV  = 8'd1;
   localparam logic [7:0] SUB_EADDR = 8'd3;
   localparam logic [7:0] SUB_PC    = 8'd10;

endpackage

// File: rtl/trc_lane_asm.sv
// Little-endian field assembler: each accepted payload byte is written into
// the lane named by the byte counter; the final byte is bypassed to the
// output and the lanes clear for the next field.
module trc_lane_asm #(
   parameter int NLANE = 8,
   localparam int LW = $clog2(NLANE)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 wr,
   input  logic                 last,
   input  logic [LW-1:0]        lane,
   input  logic [7:0]           din,
   output logic [8*NLANE-1:0]   merged
);

   if (NLANE < 2 || (NLANE & (NLANE - 1)) != 0) begin : g_bad_nlane
      $error("trc_lane_asm: NLANE must be a power of two, at least 2");
   end

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      logic [7:0] q;
      logic       hit;
      assign hit = wr && (lane == LW'(g));
      always_ff @(posedge clk) begin
         if (rst || (wr && last)) q <= '0;
         else if (hit)            q <= din;
      end
      assign merged[g*8 +: 8] = hit ? din : q;
   end

endmodule

// File: rtl/trc_evt_hold.sv
// One-deep output holding register with valid/ready handshake.
module trc_evt_hold
   import trc_pkg::*;
#(
   parameter int VW = 64,
   parameter int RW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  trc_kind_e     kind_d,
   input  logic [RW-1:0] reg_d,
   input  logic [VW-1:0] val_d,
   input  logic          rdy,
   output logic          valid,
   output trc_kind_e     kind_q,
   output logic [RW-1:0] reg_q,
   output logic [VW-1:0] val_q
);

   if (VW < 8 || RW < 1) begin : g_bad_width
      $error("trc_evt_hold: widths out of range");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         valid  <= 1'b0;
         kind_q <= K_REGWR;
         reg_q  <= '0;
         val_q  <= '0;
      end else if (load) begin
         valid  <= 1'b1;
         kind_q <= kind_d;
         reg_q  <= reg_d;
         val_q  <= val_d;
      end else if (rdy) begin
         valid  <= 1'b0;
      end
   end

   // R8
   load_free_chk: assert property (@(posedge clk) disable iff (rst)
      load |-> (!valid || rdy));

   // R8
   hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (valid && !rdy) |=> (valid && $stable(val_q) && $stable(reg_q) && $stable(kind_q)));

endmodule

// File: rtl/trc_parse_fsm.sv
// Item parser: tracks the position in the stream, sizes each payload field,
// and decides when an event is produced.
module trc_parse_fsm
   import trc_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        acc,
   input  logic [7:0]  din,
   input  logic [63:0] merged,
   output logic        asm_wr,
   output logic        asm_last,
   output logic [2:0]  asm_lane,
   output logic        ev_load,
   output trc_kind_e   ev_kind,
   output logic [15:0] ev_reg,
   output logic [63:0] ev_val,
   output logic        at_opc,
   output logic        grp_done,
   output logic        err
);

   logic [2:0] xb_m1;

   if (XLEN == 64) begin : g_x64
      assign xb_m1 = 3'd7;
   end else if (XLEN == 32) begin : g_x32
      assign xb_m1 = 3'd3;
   end else begin : g_xbad
      assign xb_m1 = 3'd0;
      $error("trc_parse_fsm: XLEN must be 32 or 64");
   end

   trc_state_e  state, nxt;
   logic [2:0]  cnt, need_m1, nxt_need;
   trc_kind_e   pay_kind, nxt_kind;
   logic [15:0] pay_reg, nxt_reg;
   logic        in_pay, last, load, zero_val, bad, close_hit;

   assign in_pay = state inside {ST_RNUM, ST_RVAL, ST_ASPAY, ST_INSTR, ST_MADDR, ST_MDATA};
   assign last   = (cnt == need_m1);

   always_comb begin
      nxt       = state;
      nxt_need  = need_m1;
      nxt_kind  = pay_kind;
      nxt_reg   = pay_reg;
      load      = 1'b0;
      zero_val  = 1'b0;
      bad       = 1'b0;
      close_hit = 1'b0;
      if (acc) begin
         case (state)
            ST_OUT: begin
               if (din == B_OPEN) nxt = ST_OPC;
               else               bad = 1'b1;
            end
            ST_OPC: begin
               case (din)
                  B_CLOSE: begin nxt = ST_OUT; close_hit = 1'b1; end
                  B_REGW:  begin nxt = ST_RNUM; nxt_need = 3'd1; end
                  B_AUX:   nxt = ST_SUB;
                  B_INS16: begin
                     nxt = ST_INSTR; nxt_need = 3'd1; nxt_kind = K_INS16; nxt_reg = '0;
                  end
                  B_INS32: begin
                     nxt = ST_INSTR; nxt_need = 3'd3; nxt_kind = K_INS32; nxt_reg = '0;
                  end
                  B_HRST: begin
                     load = 1'b1; zero_val = 1'b1; nxt_kind = K_HRST; nxt_reg = '0;
                  end
                  B_SINIT: begin
                     load = 1'b1; zero_val = 1'b1; nxt_kind = K_SINIT; nxt_reg = '0;
                  end
                  B_MREQ: begin
                     nxt = ST_MADDR; nxt_need = xb_m1; nxt_kind = K_MADDR; nxt_reg = '0;
                  end
                  default: begin bad = 1'b1; nxt = ST_OUT; end
               endcase
            end
            ST_RNUM: begin
               if (last) begin
                  nxt = ST_RVAL; nxt_need = xb_m1; nxt_kind = K_REGWR; nxt_reg = merged[15:0];
               end
            end
            ST_SUB: begin
               nxt     = ST_ASPAY;
               nxt_reg = '0;
               if (din == SUB_PRIV) begin
                  nxt_need = 3'd0;  nxt_kind = K_PRIV;
               end else if (din == SUB_PC) begin
                  nxt_need = xb_m1; nxt_kind = K_PC;
               end else if (din == SUB_EADDR) begin
                  nxt_need = xb_m1; nxt_kind = K_EADDR;
               end else if (din[7:2] == 6'd1) begin
                  nxt_need = 3'((4'd1 << din[1:0]) - 4'd1);
                  nxt_kind = K_STDATA;
                  nxt_reg  = {14'd0, din[1:0]};
               end else begin
                  bad = 1'b1; nxt = ST_OUT;
               end
            end
            ST_MADDR: begin
               if (last) begin load = 1'b1; nxt = ST_MATTR; end
            end
            ST_MATTR: begin
               nxt      = ST_MDATA;
               nxt_need = 3'((4'd1 << din[5:4]) - 4'd1);
               nxt_kind = K_MDATA;
               nxt_reg  = {8'd0, din};
            end
            ST_RVAL, ST_ASPAY, ST_INSTR, ST_MDATA: begin
               if (last) begin load = 1'b1; nxt = ST_OPC; end
            end
            default: nxt = ST_OUT;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_OUT;
         cnt      <= '0;
         need_m1  <= '0;
         pay_kind <= K_REGWR;
         pay_reg  <= '0;
         grp_done <= 1'b0;
         err      <= 1'b0;
      end else begin
         state    <= nxt;
         need_m1  <= nxt_need;
         pay_kind <= nxt_kind;
         pay_reg  <= nxt_reg;
         grp_done <= close_hit;
         if (bad)    err <= 1'b1;
         if (asm_wr) cnt <= last ? 3'd0 : cnt + 3'd1;
      end
   end

   assign asm_wr   = acc && in_pay;
   assign asm_last = last;
   assign asm_lane = cnt;
   assign ev_load  = load;
   assign ev_kind  = nxt_kind;
   assign ev_reg   = nxt_reg;
   assign ev_val   = zero_val ? 64'd0 : merged;
   assign at_opc   = (state == ST_OPC);

   // R9
   err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      err |=> err);

   // R1
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      grp_done |=> !grp_done);

   // R1
   done_outside_chk: assert property (@(posedge clk) disable iff (rst)
      grp_done |-> (state == ST_OUT));

   // R2
   lane_bound_chk: assert property (@(posedge clk) disable iff (rst)
      in_pay |-> (cnt <= need_m1));

   // R10
   rst_clean_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (state == ST_OUT && !err && cnt == 3'd0));

endmodule

// File: rtl/trace_stream_parser.sv
module trace_stream_parser
   import trc_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        in_valid,
   input  logic [7:0]  in_data,
   output logic        in_ready,
   output logic        ev_valid,
   input  logic        ev_ready,
   output logic [3:0]  ev_kind,
   output logic [15:0] ev_regnum,
   output logic [63:0] ev_value,
   output logic        grp_done,
   output logic        err_flag
);

   localparam int VW    = 64;
   localparam int NLANE = VW / 8;
   localparam int LW    = $clog2(NLANE);

   if (LW != 3) begin : g_bad_lanes
      $error("trace_stream_parser: lane counter expects eight lanes");
   end

   logic            acc, asm_wr, asm_last, ev_load, at_opc;
   logic [LW-1:0]   asm_lane;
   logic [VW-1:0]   merged, ld_val;
   logic [15:0]     ld_reg;
   trc_kind_e       ld_kind, kind_q;

   assign in_ready = !ev_valid || ev_ready;
   assign acc      = in_valid && in_ready;

   trc_parse_fsm #(.XLEN(XLEN)) u_fsm (
      .clk      (clk),
      .rst      (rst),
      .acc      (acc),
      .din      (in_data),
      .merged   (merged),
      .asm_wr   (asm_wr),
      .asm_last (asm_last),
      .asm_lane (asm_lane),
      .ev_load  (ev_load),
      .ev_kind  (ld_kind),
      .ev_reg   (ld_reg),
      .ev_val   (ld_val),
      .at_opc   (at_opc),
      .grp_done (grp_done),
      .err      (err_flag)
   );

   trc_lane_asm #(.NLANE(NLANE)) u_asm (
      .clk    (clk),
      .rst    (rst),
      .wr     (asm_wr),
      .last   (asm_last),
      .lane   (asm_lane),
      .din    (in_data),
      .merged (merged)
   );

   trc_evt_hold #(.VW(VW), .RW(16)) u_hold (
      .clk    (clk),
      .rst    (rst),
      .load   (ev_load),
      .kind_d (ld_kind),
      .reg_d  (ld_reg),
      .val_d  (ld_val),
      .rdy    (ev_ready),
      .valid  (ev_valid),
      .kind_q (kind_q),
      .reg_q  (ev_regnum),
      .val_q  (ev_value)
   );

   assign ev_kind = kind_q;

   // R6
   mark_evt_chk: assert property (@(posedge clk) disable iff (rst)
      (acc && at_opc && (in_data == B_HRST || in_data == B_SINIT))
      |=> (ev_valid && (ev_kind == 4'd7 || ev_kind == 4'd8) && ev_value == 64'd0));

endmodule

// File: tb/sim_trace_stream_parser.sv
`timescale 1ns/1ps
module sim_trace_stream_parser;

   localparam int XL = 64;
   localparam int XB = XL / 8;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic        ev_ready = 1'b0;
   logic        in_ready, ev_valid, grp_done, err_flag;
   logic [3:0]  ev_kind;
   logic [15:0] ev_regnum;
   logic [63:0] ev_value;

   trace_stream_parser #(.XLEN(XL)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .ev_valid(ev_valid), .ev_ready(ev_ready),
      .ev_kind(ev_kind), .ev_regnum(ev_regnum), .ev_value(ev_value),
      .grp_done(grp_done), .err_flag(err_flag)
   );

   always #2.5 clk = ~clk;

   int n_chk = 0, n_fail = 0, exp_done = 0, got_done = 0;
   int cyc = 0;
   logic [7:0]  byte_q [$];
   logic [83:0] exp_q [$];

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [83:0] act, input logic [83:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic string kreq(input logic [3:0] k);
      case (k)
         4'd0:             return "R2 register write";
         4'd1, 4'd2, 4'd3: return "R3 additional state";
         4'd4:             return "R4 store data";
         4'd5, 4'd6:       return "R5 instruction";
         4'd7, 4'd8:       return "R6 marker";
         default:          return "R7 memory request";
      endcase
   endfunction

   function automatic logic [63:0] msk(input logic [63:0] v, input int n);
      return (n >= 8) ? v : (v & ((64'd1 << (8 * n)) - 64'd1));
   endfunction

   task automatic put_le(input logic [63:0] v, input int n);
      for (int i = 0; i < n; i++) byte_q.push_back(v[8*i +: 8]);
   endtask

   task automatic item_reg(input logic [15:0] r, input logic [63:0] v);
      byte_q.push_back(8'd4); put_le({48'd0, r}, 2); put_le(v, XB);
      exp_q.push_back({4'd0, r, msk(v, XB)});
   endtask

   task automatic item_aux(input logic [7:0] sub, input logic [63:0] v);
      int n; logic [3:0] k; logic [15:0] r;
      r = 16'd0;
      if (sub == 8'd1)       begin n = 1;  k = 4'd1; end
      else if (sub == 8'd10) begin n = XB; k = 4'd2; end
      else if (sub == 8'd3)  begin n = XB; k = 4'd3; end
      else begin n = 1 << (sub - 4); k = 4'd4; r = 16'(sub - 4); end
      byte_q.push_back(8'd7); byte_q.push_back(sub); put_le(v, n);
      exp_q.push_back({k, r, msk(v, n)});
   endtask

   task automatic item_ins(input bit wide, input logic [63:0] v);
      byte_q.push_back(wide ? 8'd17 : 8'd16); put_le(v, wide ? 4 : 2);
      exp_q.push_back({wide ? 4'd6 : 4'd5, 16'd0, msk(v, wide ? 4 : 2)});
   endtask

   task automatic item_mark(input bit sinit);
      byte_q.push_back(sinit ? 8'd11 : 8'd10);
      exp_q.push_back({sinit ? 4'd8 : 4'd7, 16'd0, 64'd0});
   endtask

   task automatic item_mem(input logic [63:0] a, input logic [7:0] attr, input logic [63:0] d);
      int n;
      n = 1 << attr[5:4];
      byte_q.push_back(8'd8); put_le(a, XB);
      exp_q.push_back({4'd9, 16'd0, msk(a, XB)});
      byte_q.push_back(attr); put_le(d, n);
      exp_q.push_back({4'd10, {8'd0, attr}, msk(d, n)});
   endtask

   task automatic g_open();  byte_q.push_back(8'd1); endtask
   task automatic g_close(); byte_q.push_back(8'd2); exp_done++; endtask

   function automatic logic [63:0] r64();
      return {$urandom, $urandom};
   endfunction

   // mode 0: random valid/ready, 1: ready held low, 2: always valid and ready
   task automatic step(input int mode);
      logic [83:0] act, e;
      @(negedge clk);
      in_valid = (byte_q.size() > 0) && (mode != 0 || ($urandom % 4 != 0));
      in_data  = (byte_q.size() > 0) ? byte_q[0] : 8'h00;
      ev_ready = (mode == 1) ? 1'b0 : (mode == 2) ? 1'b1 : ($urandom % 3 != 0);
      #1;
      if (grp_done) got_done++;
      if (ev_valid && ev_ready) begin
         act = {ev_kind, ev_regnum, ev_value};
         if (exp_q.size() == 0) chk(1'b0, "R8/R9 unexpected event", act, '0);
         else begin
            e = exp_q.pop_front();
            chk(act === e, kreq(e[83:80]), act, e);
         end
      end
      if (in_valid && in_ready) void'(byte_q.pop_front());
   endtask

   task automatic drain(input string tag);
      int guard = 0;
      while ((byte_q.size() > 0 || exp_q.size() > 0) && guard < 100000) begin
         step(0); guard++;
      end
      repeat (4) step(0);
      chk(exp_q.size() == 0 && byte_q.size() == 0, {"R8 all events delivered: ", tag},
          84'(exp_q.size()), 84'd0);
      chk(got_done == exp_done, {"R1 group-done count: ", tag}, 84'(got_done), 84'(exp_done));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b0; ev_ready = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      got_done = 0; exp_done = 0;
      byte_q.delete(); exp_q.delete();
   endtask

   initial begin
      void'($urandom(32'h5eed_0713));
      do_reset();
      #1;
      // R10 reset state
      chk(in_ready && !ev_valid && !grp_done && !err_flag, "R10 reset state",
          {in_ready, ev_valid, grp_done, err_flag}, 84'h8);

      // Directed: every item type, register-number families, all sizes
      g_open();
      item_reg(16'h1005, 64'h0123_4567_89ab_cdef);
      item_reg(16'h1023, 64'hffee_ddcc_bbaa_9988);
      item_reg(16'h0300, 64'h0000_0000_8000_0001);
      item_aux(8'd1, 64'h3);
      item_aux(8'd10, 64'h8000_0000_0000_1000);
      item_aux(8'd3, 64'hdead_beef_0000_0040);
      g_close();
      g_open();
      for (int s = 4; s < 8; s++) item_aux(8'(s), 64'hf1e2_d3c4_b5a6_9788);
      item_ins(1'b0, 64'h4501);
      item_ins(1'b1, 64'h0002_8293);
      item_mark(1'b0);
      item_mark(1'b1);
      for (int s = 0; s < 4; s++) item_mem(r64(), {2'b00, 2'(s), 4'd1}, r64());
      g_close();
      drain("directed");

      // R8 latency: event valid in the cycle after its final byte
      g_open(); item_ins(1'b0, 64'h1234); g_close();
      while (byte_q.size() > 1) step(2);
      @(negedge clk);
      in_valid = 1'b0; ev_ready = 1'b0;
      #1;
      chk(ev_valid && ev_kind == 4'd5 && ev_value == 64'h1234, "R8 one-cycle latency",
          {ev_valid, ev_kind, ev_value}, {1'b1, 4'd5, 64'h1234});
      drain("latency");

      // R8 stall: ready held low, input must block and event hold
      g_open(); item_mark(1'b0); item_mark(1'b1); g_close();
      repeat (12) step(1);
      chk(ev_valid && ev_kind == 4'd7 && ev_value == 64'd0, "R8 event held under stall",
          {ev_valid, ev_kind, ev_value}, {1'b1, 4'd7, 64'd0});
      chk(!in_ready, "R8 input blocked under stall", 84'(in_ready), 84'd0);
      chk(byte_q.size() == 2, "R8 no byte taken under stall", 84'(byte_q.size()), 84'd2);
      drain("stall");

      // Random groups
      for (int g = 0; g < 300; g++) begin
         g_open();
         for (int i = 0; i < 1 + int'($urandom % 4); i++) begin
            case ($urandom % 7)
               0: item_reg(16'($urandom), r64());
               1: begin
                  int pick = int'($urandom % 7);
                  item_aux(pick == 0 ? 8'd1 : pick == 1 ? 8'd3 : pick == 2 ? 8'd10 : 8'(pick + 1), r64());
               end
               2: item_ins(1'b0, r64());
               3: item_ins(1'b1, r64());
               4: item_mark(1'b0);
               5: item_mark(1'b1);
               default: item_mem(r64(), 8'($urandom), r64());
            endcase
         end
         g_close();
      end
      drain("random");
      chk(!err_flag, "R9 no error on well-formed stream", 84'(err_flag), 84'd0);

      // R9 stray bytes between groups
      do_reset();
      byte_q.push_back(8'd5); byte_q.push_back(8'd2);
      g_open(); item_reg(16'h1001, 64'h55); g_close();
      drain("stray");
      chk(err_flag, "R9 stray byte sets error", 84'(err_flag), 84'd1);

      do_reset();
      #1;
      chk(!err_flag, "R10 reset clears error", 84'(err_flag), 84'd0);

      // R9 unknown opcode, rest discarded until open byte
      byte_q.push_back(8'd1); byte_q.push_back(8'h33);
      byte_q.push_back(8'd4); byte_q.push_back(8'h55); byte_q.push_back(8'h66);
      byte_q.push_back(8'd2); byte_q.push_back(8'd2);
      g_open(); item_mark(1'b1); g_close();
      drain("bad opcode");
      chk(err_flag, "R9 unknown opcode sets error", 84'(err_flag), 84'd1);

      // R9 unknown subtype
      do_reset();
      byte_q.push_back(8'd1); byte_q.push_back(8'd7); byte_q.push_back(8'd9);
      byte_q.push_back(8'h20); byte_q.push_back(8'd2);
      g_open(); item_aux(8'd1, 64'h1); g_close();
      drain("bad subtype");
      chk(err_flag, "R9 unknown subtype sets error", 84'(err_flag), 84'd1);

      // R10 reset in the middle of an item
      do_reset();
      byte_q.push_back(8'd1); byte_q.push_back(8'd4); byte_q.push_back(8'h05);
      byte_q.push_back(8'h10); byte_q.push_back(8'h99);
      while (byte_q.size() > 0) step(0);
      do_reset();
      g_open(); item_reg(16'h1002, 64'hcafe_f00d_1234_5678); item_mark(1'b0); g_close();
      drain("mid-item reset");
      chk(!err_flag, "R10 partial item discarded by reset", 84'(err_flag), 84'd0);

      summary();
      $finish;
   end

endmodule